// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that software reaches over an 8-bit register bus. The count source is one of two. The first is an internal tick at one quarter of the system clock rate. The second is the rising edges of an external clock pin, taken either through a two-flop synchronizer or through a single-flop edge detector with lower latency. The chosen source passes through a divide-by-1/2/4/8 prescaler before it reaches the counter. A run bit gates counting. A compare unit can clear the count through a trigger input. A wrap from 0xFFFF to 0x0000 sets a sticky overflow flag, and that flag drives the interrupt output.

The bus has three byte addresses: 0 is the count low byte, 1 is the count high byte and 2 is the control register. A control bit selects the buffered 16-bit access mode. In that mode a read of the low byte captures the high byte into a buffer, and a write of the low byte loads the buffered high byte together with it. Both bytes therefore move as one value even while the counter is running.

Top module: `tmr16_core`

## Requirements
- R1: After reset the count is 0x0000, the control register at address 2 reads 0x00 and `ovf_irq` is low.
- R2: With control bit 1 at 0 and control bit 0 at 1, the count advances once every 4 system clocks (prescaler ratio 1).
- R3: With control bit 1 at 1, the count advances once per rising edge of `ext_clk`. Control bit 2 at 0 routes the edge through a two-flop synchronizer. Control bit 2 at 1 detects the edge against one registered copy of the pin.
- R4: Control bits 4:3 select a prescaler ratio of 1, 2, 4 or 8 (codes 0 to 3). The ratio applies to either source.
- R5: While control bit 0 is 0, the count holds and `ext_clk` edges have no effect on it.
- R6: A wrap of the count from 0xFFFF to 0x0000 sets the overflow flag (control bit 7). The flag stays set, and `ovf_irq` follows it.
- R7: A control write with bit 7 at 0 clears the flag, and a write with bit 7 at 1 leaves it unchanged. When a clear and a wrap fall in the same cycle, the flag ends up set.
- R8: A high level on `special_clr` makes the count 0x0000 at the next clock edge, ahead of any bus load or advance in that cycle.
- R9: With control bit 5 at 0, reads and writes of address 1 reach the count's upper byte directly, and a write of address 0 replaces only the lower byte.
- R10: With control bit 5 at 1, a read of address 0 copies the count's upper byte into a buffer, and a read of address 1 returns that buffer.
- R11: With control bit 5 at 1, a write of address 1 changes only the buffer. A later write of address 0 loads the buffer and the written byte into the count together.
- R12: Any bus write that loads the count also resets the prescaler's divide counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | External count clock |
| special_clr | input | 1 | Compare-match trigger that clears the count |
| bus_addr | input | 2 | Register byte address |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe; a read side effect happens at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ovf_irq | output | 1 | Overflow interrupt flag |

## Verification
Bus writes, the trigger clear and buffer captures take effect at the first clock edge after the strobe. Read data is combinational, so the bench samples it 1 ns after the negative edge on which the address is set. An external edge reaches the count three edges after the pin rises on the synchronized path and one edge after on the direct path. The bench therefore holds each pin level for four clocks and reads the count only after the pulse has ended and the count is stopped. The internal-tick checks enable and disable the count a fixed number of edges apart, because any window of 40 consecutive clocks contains exactly 10 ticks whatever the phase.

// File: rtl/tmr16_pkg.sv
// Package: shared constants and types for the prescaled timer/counter.
// Assumes a byte-wide register bus with a 2-bit address.
package tmr16_pkg;

    localparam int PS_W = 2;

    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_CTL  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // Control register layout, most significant bit first.
    typedef struct packed {
        logic            flag;
        logic            spare;
        logic            wide;
        logic [PS_W-1:0] ps;
        logic            no_sync;
        logic            ext_src;
        logic            run;
    } ctl_t;

endpackage

// File: rtl/tmr16_src.sv
// Module: count-source selection. Produces a one-cycle tick either from an
// internal divide-by-IC_DIV phase counter or from a rising edge on the
// external pin, taken through a SYNC_STAGES-flop synchronizer or directly.
// Assumes IC_DIV >= 2 and SYNC_STAGES >= 1.
module tmr16_src #(
    parameter int IC_DIV      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic ext_src,
    input  logic no_sync,
    output logic src_tick
);
    localparam int PH_W = (IC_DIV > 1) ? $clog2(IC_DIV) : 1;

    logic [PH_W-1:0]      ph_q;
    logic [SYNC_STAGES:0] sh_q;
    logic                 raw_q;
    logic                 int_tick, sync_rise, raw_rise;

    // Free-running instruction-rate phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ph_q <= '0;
        else if (ph_q == PH_W'(IC_DIV - 1))   ph_q <= '0;
        else                                  ph_q <= ph_q + 1'b1;
    end

    // Synchronizer chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], ext_in};
    end

    // Single-flop history for the unsynchronized edge path.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= ext_in;
    end

    // Tick selection between internal and the two external paths.
    always_comb begin
        int_tick  = (ph_q == PH_W'(IC_DIV - 1));
        sync_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
        raw_rise  = ext_in & ~raw_q;
        if (!ext_src)     src_tick = int_tick;
        else if (no_sync) src_tick = raw_rise;
        else              src_tick = sync_rise;
    end
endmodule

// File: rtl/tmr16_pscl.sv
// Module: prescaler. Passes every 2**ps-th input tick while enabled.
// The divide counter clears on request and only advances while enabled.
module tmr16_pscl #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [PS_W-1:0] ps,
    input  logic            clr,
    input  logic            tick_in,
    output logic            tick_out
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Ratio mask and output tick when all masked bits are set.
    always_comb begin
        mask     = ~({DIV_W{1'b1}} << ps);
        tick_out = en & tick_in & ((div_q & mask) == mask);
    end

    // Divide counter: cleared on bus load, stepped on each enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n)              div_q <= '0;
        else if (clr)            div_q <= '0;
        else if (en && tick_in)  div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/tmr16_cnt.sv
// Module: the count register. Priority: trigger clear, bus load, advance.
// Reports a wrap pulse only when an advance actually takes all-ones to zero.
module tmr16_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr_evt,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    // Wrap detection for the overflow flag.
    always_comb wrap = adv & ~clr_evt & ~ld & (cnt == {CNT_W{1'b1}});

    // Count update with clear over load over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clr_evt) cnt <= '0;
        else if (ld)      cnt <= ld_val;
        else if (adv)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmr16_regs.sv
// Module: byte-bus register file. Holds control, the overflow flag and the
// high-byte buffer, and decodes count loads in 8-bit and buffered modes.
// Assumes the count is exactly two bus bytes wide.
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         addr,
    input  logic               wr,
    input  logic               rd,
    input  logic [BUS_W-1:0]   wdata,
    output logic [BUS_W-1:0]   rdata,
    input  logic [2*BUS_W-1:0] cnt,
    input  logic               wrap,
    output ctl_t               ctl,
    output logic               ld,
    output logic [2*BUS_W-1:0] ld_val,
    output logic               flag_clr
);
    logic [BUS_W-1:0] hbuf_q;
    logic             wr_lo, wr_hi, wr_ctl, rd_lo;
    ctl_t             ctl_w;

    // Address decode and count-load formation.
    always_comb begin
        wr_lo    = wr & (reg_sel_e'(addr) == REG_LO);
        wr_hi    = wr & (reg_sel_e'(addr) == REG_HI);
        wr_ctl   = wr & (reg_sel_e'(addr) == REG_CTL);
        rd_lo    = rd & (reg_sel_e'(addr) == REG_LO);
        flag_clr = wr_ctl & ~wdata[BUS_W-1];
        ctl_w    = ctl_t'(wdata);
        ld       = wr_lo | (wr_hi & ~ctl.wide);
        if (wr_lo) ld_val = ctl.wide ? {hbuf_q, wdata} : {cnt[2*BUS_W-1:BUS_W], wdata};
        else       ld_val = {wdata, cnt[BUS_W-1:0]};
    end

    // Control fields other than the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl.run     <= 1'b0;
            ctl.ext_src <= 1'b0;
            ctl.no_sync <= 1'b0;
            ctl.ps      <= '0;
            ctl.wide    <= 1'b0;
            ctl.spare   <= 1'b0;
        end else if (wr_ctl) begin
            ctl.run     <= ctl_w.run;
            ctl.ext_src <= ctl_w.ext_src;
            ctl.no_sync <= ctl_w.no_sync;
            ctl.ps      <= ctl_w.ps;
            ctl.wide    <= ctl_w.wide;
            ctl.spare   <= ctl_w.spare;
        end
    end

    // Sticky overflow flag: a wrap beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl.flag <= 1'b0;
        else if (wrap)     ctl.flag <= 1'b1;
        else if (flag_clr) ctl.flag <= 1'b0;
    end

    // High-byte buffer: written by the bus or captured on a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)                   hbuf_q <= '0;
        else if (wr_hi && ctl.wide)   hbuf_q <= wdata;
        else if (rd_lo && ctl.wide)   hbuf_q <= cnt[2*BUS_W-1:BUS_W];
    end

    // Read multiplexer.
    always_comb begin
        case (reg_sel_e'(addr))
            REG_LO:  rdata = cnt[BUS_W-1:0];
            REG_HI:  rdata = ctl.wide ? hbuf_q : cnt[2*BUS_W-1:BUS_W];
            REG_CTL: rdata = ctl;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr16_core.sv
// Module: top of the prescaled 16-bit timer/counter. Connects the source
// selector, prescaler, count register and byte-bus register file.
// Assumes a single system clock domain; ext_clk is treated as asynchronous.
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int IC_DIV      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk,
    input  logic             special_clr,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             ovf_irq
);
    localparam int CNT_W = 2 * BUS_W;

    ctl_t             ctl;
    logic             src_tick, adv, cnt_ld, wrap, flag_clr, run_en;
    logic [CNT_W-1:0] cnt_q, ld_val;

    assign run_en  = ctl.run;
    assign ovf_irq = ctl.flag;

    tmr16_src #(.IC_DIV(IC_DIV), .SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_clk),
        .ext_src(ctl.ext_src), .no_sync(ctl.no_sync), .src_tick(src_tick)
    );

    tmr16_pscl #(.PS_W(PS_W)) u_pscl (
        .clk(clk), .rst_n(rst_n), .en(run_en), .ps(ctl.ps),
        .clr(cnt_ld), .tick_in(src_tick), .tick_out(adv)
    );

    tmr16_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .adv(adv), .clr_evt(special_clr),
        .ld(cnt_ld), .ld_val(ld_val), .cnt(cnt_q), .wrap(wrap)
    );

    tmr16_regs #(.BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata), .cnt(cnt_q), .wrap(wrap),
        .ctl(ctl), .ld(cnt_ld), .ld_val(ld_val), .flag_clr(flag_clr)
    );
endmodule

// File: rtl/tmr16_chk.sv
// Module: property checker for tmr16_core, attached by bind below.
module tmr16_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv,
    input logic             run,
    input logic             cnt_ld,
    input logic             special_clr,
    input logic             flag_clr,
    input logic             ovf_irq,
    input logic [CNT_W-1:0] cnt
);
    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !special_clr && !cnt_ld) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R5
    off_no_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !adv);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !special_clr && !cnt_ld) |=> $stable(cnt));

    // R6
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !special_clr && !cnt_ld && cnt == {CNT_W{1'b1}}) |=> ovf_irq);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_irq && !flag_clr) |=> ovf_irq);

    // R8
    trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        special_clr |=> cnt == '0);
endmodule

bind tmr16_core tmr16_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .adv(adv), .run(run_en), .cnt_ld(cnt_ld),
    .special_clr(special_clr), .flag_clr(flag_clr), .ovf_irq(ovf_irq), .cnt(cnt_q)
);

// File: tb/tmr16_core_test.sv
module tmr16_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       special_clr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ovf_irq;

    int checks = 0;
    int fails  = 0;

    localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTL = 2'd2;

    // {unsync at bit 24, ps at 17:16, pulses at 15:8, expected count at 7:0}
    localparam logic [31:0] VEC [6] = '{
        32'h0000_0505, 32'h0001_0603, 32'h0002_0902,
        32'h0003_1102, 32'h0100_0707, 32'h0102_0802
    };

    always #5 clk = ~clk;

    tmr16_core uut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .special_clr(special_clr),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_irq(ovf_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        br(A_LO, lo);
        br(A_HI, hi);
        v = {hi, lo};
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic set16(input logic [15:0] v);
        bw(A_HI, v[15:8]);
        bw(A_LO, v[7:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        br(A_CTL, b); chk("R1 ctl", b, 8'h00);
        rd16(v);      chk("R1 count", v, 16'h0000);
        chk("R1 irq", ovf_irq, 1'b0);

        // R3/R4 external paths and ratios from the vector table
        for (int k = 0; k < 6; k++) begin
            bw(A_CTL, 8'h00);
            set16(16'h0000);
            bw(A_CTL, 8'h03 | (VEC[k][24] ? 8'h04 : 8'h00) | {3'b000, VEC[k][17:16], 3'b000});
            pulse(int'(VEC[k][15:8]));
            bw(A_CTL, 8'h00);
            rd16(v);
            chk($sformatf("R3/R4 vec %0d", k), v, {8'h00, VEC[k][7:0]});
        end

        // R2 internal tick: 40 enabled edges give 10 advances
        set16(16'h0000);
        bw(A_CTL, 8'h01);
        repeat (38) @(negedge clk);
        bw(A_CTL, 8'h00);
        rd16(v); chk("R2 internal rate", v, 16'd10);

        // R4 internal tick with ratio 4: 160 edges give 10 advances
        set16(16'h0000);
        bw(A_CTL, 8'h11);
        repeat (158) @(negedge clk);
        bw(A_CTL, 8'h00);
        rd16(v); chk("R4 internal ratio 4", v, 16'd10);

        // R5 run bit off: edges ignored
        set16(16'h0042);
        bw(A_CTL, 8'h06);
        pulse(3);
        rd16(v); chk("R5 hold", v, 16'h0042);

        // R9 direct high-byte access
        bw(A_CTL, 8'h00);
        bw(A_HI, 8'h12);
        br(A_HI, b); chk("R9 direct high", b, 8'h12);
        br(A_LO, b); chk("R9 low kept", b, 8'h42);

        // R6 overflow and sticky flag
        set16(16'hFFFE);
        bw(A_CTL, 8'h07);
        pulse(1);
        chk("R6 no flag before wrap", ovf_irq, 1'b0);
        pulse(1);
        chk("R6 flag on wrap", ovf_irq, 1'b1);
        br(A_CTL, b); chk("R6 ctl bit7", b[7], 1'b1);
        rd16(v); chk("R6 wrapped count", v, 16'h0000);
        // R7 writing bit7 as 1 keeps the flag
        bw(A_CTL, 8'h87);
        chk("R7 write one no effect", ovf_irq, 1'b1);
        pulse(1);
        chk("R6 sticky", ovf_irq, 1'b1);
        // R7 writing bit7 as 0 clears
        bw(A_CTL, 8'h07);
        chk("R7 clear", ovf_irq, 1'b0);

        // R7 wrap and clear in the same cycle: wrap wins
        bw(A_CTL, 8'h80);
        set16(16'hFFFF);
        bw(A_CTL, 8'h87);
        pulse(1);
        chk("R7 flag set again", ovf_irq, 1'b1);
        bw(A_CTL, 8'h80);
        set16(16'hFFFF);
        bw(A_CTL, 8'h87);
        @(negedge clk);
        ext_clk = 1'b1; bus_addr = A_CTL; bus_wdata = 8'h07; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 set wins over clear", ovf_irq, 1'b1);
        bw(A_CTL, 8'h00);
        rd16(v); chk("R7 count wrapped", v, 16'h0000);

        // R8 trigger clear, alone and against a load
        set16(16'h1234);
        @(negedge clk); special_clr = 1'b1;
        @(negedge clk); special_clr = 1'b0;
        rd16(v); chk("R8 trigger clear", v, 16'h0000);
        set16(16'h1234);
        @(negedge clk);
        special_clr = 1'b1; bus_addr = A_LO; bus_wdata = 8'h55; bus_wr = 1'b1;
        @(negedge clk);
        special_clr = 1'b0; bus_wr = 1'b0;
        rd16(v); chk("R8 clear beats load", v, 16'h0000);

        // R11 buffered write goes to buffer only, then loads both bytes
        bw(A_CTL, 8'h20);
        bw(A_HI, 8'hAB);
        br(A_HI, b); chk("R11 buffer holds write", b, 8'hAB);
        bw(A_CTL, 8'h00);
        br(A_HI, b); chk("R11 count high untouched", b, 8'h00);
        bw(A_CTL, 8'h20);
        bw(A_HI, 8'h12);
        bw(A_LO, 8'hFF);
        bw(A_CTL, 8'h00);
        rd16(v); chk("R11 joint load", v, 16'h12FF);

        // R10 low read captures high byte while counting
        bw(A_CTL, 8'h27);
        br(A_LO, b); chk("R10 low read", b, 8'hFF);
        pulse(1);
        br(A_HI, b); chk("R10 buffered high", b, 8'h12);
        bw(A_CTL, 8'h00);
        br(A_HI, b); chk("R10 live high", b, 8'h13);

        // R12 count write resets prescaler divide counter
        set16(16'h0000);
        bw(A_CTL, 8'h1F);
        pulse(5);
        bw(A_LO, 8'h00);
        pulse(7);
        bw(A_CTL, 8'h18);
        rd16(v); chk("R12 divider reset", v, 16'h0000);
        bw(A_CTL, 8'h1F);
        pulse(1);
        bw(A_CTL, 8'h18);
        rd16(v); chk("R12 eighth edge", v, 16'h0001);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule